// File: doc/BRIEF.md
# Manchester Frame Sync Monitor

This block follows the one sync bit that each frame of a Manchester-coded stream carries. That bit should flip from every frame to the next. The decoder ahead of this block pulses `frame_stb` once per frame and presents the recovered bit on `sync_bit`. The monitor keeps a lock flag that is set once the alternation has been seen for long enough. It also raises a one-cycle error pulse whenever a frame repeats the previous frame's bit.

While locked, a single error does not drop the flag. The first error opens a window of a fixed number of frames. The flag clears only if the error count reaches the limit before that window runs out. A window that expires with fewer errors is thrown away, and the next error opens a new one. After a loss the monitor returns to acquisition and takes a fresh reference bit. One instance serves one decoder channel, and several may sit side by side.

Top module: `mfs_sync_monitor`

## Requirements
- R1: A synchronous active-low reset drives `locked` and `sync_err` to 0 and clears the acquisition count, the window and the stored reference bit.
- R2: A frame is a sync error when its `sync_bit` equals the bit of the previous frame received since reset or since the last loss of lock. The first frame after reset or after a loss only sets the reference and is never an error.
- R3: `sync_err` is high for exactly the one cycle after the clock edge that sampled an erroneous strobed frame. This holds in both the locked and the unlocked state. Without a strobe, `sync_err` stays 0.
- R4: From the unlocked state, `locked` rises on the edge that samples the 4th consecutive correctly alternating frame after the reference frame.
- R5: In acquisition, a sync error restarts the alternation count from zero, and the erroneous frame becomes the new reference.
- R6: While locked, the first sync error opens a 10-frame window, and that frame counts as frame 1. `locked` falls on the edge that samples the 3rd error inside the window, and `sync_err` is high in the same cycle.
- R7: A window that completes its 10th frame with fewer than 3 errors is closed and its count is discarded. A later error opens a fresh window with a count of 1, so earlier errors never contribute to a loss.
- R8: After a loss of lock, the monitor restarts acquisition, and the next strobed frame becomes the new reference whatever its value.
- R9: In cycles without `frame_stb`, `locked` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe, one per received frame |
| sync_bit | input | 1 | Recovered sync bit of the strobed frame |
| locked | output | 1 | 1 while the alternating sync pattern is held |
| sync_err | output | 1 | One-cycle pulse per detected sync error |

## Verification
A stale reference bit shows up on the very next strobe: `sync_err` fires on a good frame, or stays silent on a repeated one. An acquisition count that is off by one moves the rising edge of `locked` by a whole frame. A window position or error count that is not cleared shows up later. Either lock is dropped on errors that belong to different windows, or it is kept through three errors in one window. A random mix of good and repeated frames, with back-to-back and spaced strobes, runs up against both of these edges many times.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  // A frame breaks the pattern when a reference exists and the bit repeats it.
  function automatic logic breaks_alternation(logic have_ref, logic ref_bit, logic cur_bit);
    return have_ref && (ref_bit == cur_bit);
  endfunction

  // True once the frame index inside the window reaches the window length.
  function automatic logic window_expired(int unsigned pos_next, int unsigned win_len);
    return pos_next >= win_len;
  endfunction

  // True once the error tally reaches the loss limit.
  function automatic logic limit_reached(int unsigned cnt_next, int unsigned limit);
    return cnt_next >= limit;
  endfunction

endpackage

// File: rtl/mfs_ref_track.sv
module mfs_ref_track
  import mfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic sync_bit,
  input  logic reseed,
  output logic err_evt,
  output logic good_evt
);

  logic have_ref;
  logic ref_bit;
  logic brk;

  assign brk      = breaks_alternation(have_ref, ref_bit, sync_bit);
  assign err_evt  = frame_stb && brk;
  assign good_evt = frame_stb && have_ref && !brk;

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      have_ref <= 1'b0;
      ref_bit  <= 1'b0;
    end else if (frame_stb) begin
      have_ref <= 1'b1;
      ref_bit  <= sync_bit;
    end
  end

  AST_NO_EVT_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> !(err_evt || good_evt)); // R2

  AST_SEED_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !have_ref |-> !err_evt); // R2

endmodule

// File: rtl/mfs_acquire.sv
module mfs_acquire #(
  parameter int LOCK_FRAMES = 4,
  localparam int ACQ_W = $clog2(LOCK_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             good_evt,
  input  logic             err_evt,
  input  logic             lose_evt,
  output logic             lock_evt,
  output logic [ACQ_W-1:0] acq_cnt
);

  localparam logic [ACQ_W-1:0] LAST_GOOD = ACQ_W'(LOCK_FRAMES - 1);

  assign lock_evt = !locked && good_evt && (acq_cnt == LAST_GOOD);

  always_ff @(posedge clk) begin
    if (!rst_n || lose_evt || locked) begin
      acq_cnt <= '0;
    end else if (err_evt) begin
      acq_cnt <= '0;
    end else if (good_evt) begin
      acq_cnt <= lock_evt ? '0 : acq_cnt + ACQ_W'(1);
    end
  end

  AST_ACQ_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acq_cnt < ACQ_W'(LOCK_FRAMES)); // R4

  AST_ACQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && err_evt) |=> (acq_cnt == '0)); // R5

endmodule

// File: rtl/mfs_err_window.sv
module mfs_err_window
  import mfs_pkg::*;
#(
  parameter int WIN_FRAMES = 10,
  parameter int ERR_LIMIT  = 3,
  localparam int POS_W = $clog2(WIN_FRAMES + 1),
  localparam int CNT_W = $clog2(ERR_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic frame_stb,
  input  logic err_evt,
  output logic lose_evt,
  output logic win_open
);

  logic [POS_W-1:0] win_pos;
  logic [CNT_W-1:0] err_cnt;
  logic [POS_W-1:0] pos_next;
  logic [CNT_W-1:0] cnt_eff;
  logic             expire;

  assign pos_next = win_pos + POS_W'(1);
  assign cnt_eff  = win_open ? err_cnt + CNT_W'(1) : CNT_W'(1);
  assign lose_evt = locked && err_evt && limit_reached(32'(cnt_eff), ERR_LIMIT);
  assign expire   = win_open && window_expired(32'(pos_next), WIN_FRAMES);

  always_ff @(posedge clk) begin
    if (!rst_n || lose_evt || !locked) begin
      win_open <= 1'b0;
      win_pos  <= '0;
      err_cnt  <= '0;
    end else if (frame_stb) begin
      if (!win_open) begin
        if (err_evt) begin
          win_open <= 1'b1;
          win_pos  <= POS_W'(1);
          err_cnt  <= CNT_W'(1);
        end
      end else if (expire) begin
        win_open <= 1'b0;
        win_pos  <= '0;
        err_cnt  <= '0;
      end else begin
        win_pos <= pos_next;
        if (err_evt) err_cnt <= cnt_eff;
      end
    end
  end

  AST_WIN_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> locked); // R6

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt < CNT_W'(ERR_LIMIT)); // R6

  AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (win_pos != '0) && (win_pos < POS_W'(WIN_FRAMES))); // R7

  AST_WIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && win_open && win_pos == POS_W'(WIN_FRAMES - 1)) |=> !win_open); // R7

endmodule

// File: rtl/mfs_sync_monitor.sv
module mfs_sync_monitor #(
  parameter int LOCK_FRAMES = 4,
  parameter int WIN_FRAMES  = 10,
  parameter int ERR_LIMIT   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic sync_bit,
  output logic locked,
  output logic sync_err
);

  localparam int ACQ_W = $clog2(LOCK_FRAMES + 1);

  logic             err_evt;
  logic             good_evt;
  logic             lock_evt;
  logic             lose_evt;
  logic             win_open;
  logic [ACQ_W-1:0] acq_cnt;

  mfs_ref_track u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .sync_bit (sync_bit),
    .reseed   (lose_evt),
    .err_evt  (err_evt),
    .good_evt (good_evt)
  );

  mfs_acquire #(.LOCK_FRAMES(LOCK_FRAMES)) u_acq (
    .clk     (clk),
    .rst_n   (rst_n),
    .locked  (locked),
    .good_evt(good_evt),
    .err_evt (err_evt),
    .lose_evt(lose_evt),
    .lock_evt(lock_evt),
    .acq_cnt (acq_cnt)
  );

  mfs_err_window #(.WIN_FRAMES(WIN_FRAMES), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .frame_stb(frame_stb),
    .err_evt  (err_evt),
    .lose_evt (lose_evt),
    .win_open (win_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      sync_err <= err_evt;
      if (lose_evt)      locked <= 1'b0;
      else if (lock_evt) locked <= 1'b1;
    end
  end

  AST_NO_STB_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> !sync_err); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(locked)); // R9

  AST_DROP_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> sync_err); // R6

  AST_LOCK_FROM_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(acq_cnt) == ACQ_W'(LOCK_FRAMES - 1)) && !sync_err); // R4

  AST_NO_LOSE_WITHOUT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (lose_evt && ERR_LIMIT > 1) |-> win_open); // R6

endmodule

// File: tb/mfs_sync_monitor_tb.sv
module mfs_sync_monitor_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic sync_bit = 1'b0;
  logic locked;
  logic sync_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit m_have, m_prev, m_lock, m_wopen;
  int m_run, m_wpos, m_wcnt;

  always #4 clk = ~clk;

  mfs_sync_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_bit(sync_bit),
    .locked(locked), .sync_err(sync_err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_have = 0; m_prev = 0; m_lock = 0; m_wopen = 0;
    m_run = 0; m_wpos = 0; m_wcnt = 0;
  endtask

  function automatic bit model_is_err(bit b);
    return m_have && (b == m_prev);
  endfunction

  task automatic model_step(input bit b, output bit e);
    bit lost;
    e = model_is_err(b);
    lost = 0;
    if (m_lock) begin
      if (m_wopen) begin
        m_wpos++;
        if (e) m_wcnt++;
        if (m_wcnt >= 3) lost = 1;
        else if (m_wpos >= 10) begin m_wopen = 0; m_wpos = 0; m_wcnt = 0; end
      end else if (e) begin
        m_wopen = 1; m_wpos = 1; m_wcnt = 1;
      end
    end else begin
      if (e) m_run = 0;
      else if (m_have) m_run++;
      if (m_run == 4) begin m_lock = 1; m_run = 0; end
    end
    if (lost) begin
      m_lock = 0; m_have = 0; m_run = 0; m_wopen = 0; m_wpos = 0; m_wcnt = 0;
    end else begin
      m_have = 1; m_prev = b;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic send(input bit b, input int gap, input string req_e, input string req_l);
    bit e;
    @(negedge clk);
    frame_stb = 1'b1; sync_bit = b;
    model_step(b, e);
    @(negedge clk);
    frame_stb = 1'b0; sync_bit = $urandom_range(0, 1);
    chk(req_e, "sync_err", sync_err, e);
    chk(req_l, "locked", locked, m_lock);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk("R3", "sync_err idle", sync_err, 1'b0);
      chk("R9", "locked idle", locked, m_lock);
    end
  endtask

  task automatic good(input string req); send(!m_prev, 1, "R2", req); endtask
  task automatic rep(input string req);  send(m_prev, 1, "R3", req); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    do_reset();
    // R1 reset state
    chk("R1", "locked after reset", locked, 1'b0);
    chk("R1", "sync_err after reset", sync_err, 1'b0);

    // R4: seed plus three good is not enough, fourth good locks
    send(1'b0, 1, "R2", "R4");
    good("R4"); good("R4"); good("R4");
    chk("R4", "not yet locked", locked, 1'b0);
    good("R4");
    chk("R4", "locked after 4 good", locked, 1'b1);

    // R1: mid-run reset clears lock; first frame after is a seed
    do_reset();
    chk("R1", "locked cleared by reset", locked, 1'b0);
    send(1'b1, 2, "R2", "R1");
    chk("R2", "seed no error", sync_err, 1'b0);

    // R5: break during acquisition restarts count
    good("R5"); good("R5"); good("R5");
    rep("R5");
    good("R5"); good("R5"); good("R5");
    chk("R5", "restarted count not locked", locked, 1'b0);
    good("R5");
    chk("R5", "locked after restart", locked, 1'b1);

    // R6: three errors within the window drop lock
    rep("R6"); good("R6"); good("R6"); rep("R6"); good("R6");
    chk("R6", "still locked with 2 errors", locked, 1'b1);
    rep("R6");
    chk("R6", "lock lost on third error", locked, 1'b0);

    // R8: next frame reseeds regardless of value
    send(m_prev, 1, "R8", "R8");
    chk("R8", "reseed frame not error", sync_err, 1'b0);
    good("R8"); good("R8"); good("R8"); good("R8");
    chk("R8", "relocked", locked, 1'b1);

    // R7: errors at window frames 1 and 10, then a new window
    rep("R7");
    for (int i = 0; i < 8; i++) good("R7");
    rep("R7");
    rep("R7");
    good("R7");
    rep("R7");
    chk("R7", "lock kept across windows", locked, 1'b1);
    rep("R7");
    chk("R7", "third error of new window drops", locked, 1'b0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit b;
      b = ($urandom_range(0, 99) < 85) ? !m_prev : m_prev;
      if ($urandom_range(0, 199) == 0) begin
        do_reset();
        chk("R1", "locked after random reset", locked, 1'b0);
      end
      send(b, $urandom_range(0, 2), "R2", "R6");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule